// File: doc/BRIEF.md
# Configuration Shadow Refresh Controller

This block keeps volatile shadow copies of five configuration bytes that live in non-volatile storage: a control byte, an oscillator offset, a temperature coefficient, a turnover value and a data byte. Right after reset it reads all five bytes into the shadow registers. From then on, each hourly tick starts the same reload, but only when the refresh-enable bit in the shadow control byte is set. A byte that has been disturbed in a shadow register is therefore restored at the next hour.

The block also carries out user writes to the two application bytes of non-volatile storage. All memory traffic goes over one request/acknowledge port with a variable latency. A single busy output is high while the power-up load, a periodic reload or a user write is running. A tick or a write request that arrives while the block is busy is queued and served after the current operation ends. A queued reload always runs before a queued write.

Top module: `cfg_shadow_refresh`

## Requirements
- R1: While `rst_n` is low, every shadow byte is 0, `busy` is 1 and `mem_req` is 0. On the first clock edge after reset is released, `mem_req` rises with `mem_addr` equal to CFG_BASE (0x30 by default).
- R2: A load reads addresses CFG_BASE to CFG_BASE+4 in ascending order, one byte per acknowledge. The byte read from CFG_BASE+i is placed in `shadow_q[8*i +: 8]`, where i=0 is the control byte, 1 the offset, 2 the coefficient, 3 the turnover value and 4 the data byte.
- R3: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until the cycle in which `mem_ack` is high. Any acknowledge latency of one cycle or more works.
- R4: `refresh_en` equals bit 7 of the shadow control byte (`shadow_q[7]`), so it follows whatever value was last loaded.
- R5: An `hour_tick` pulse that arrives while the block is idle with `refresh_en`=1 starts a full five-byte reload. `busy` rises on the clock edge that samples the tick.
- R6: An `hour_tick` pulse that arrives while `refresh_en`=0 is dropped. It causes no memory request, no change to the shadow bytes and no busy period.
- R7: A qualified tick that arrives during an operation is remembered and served once that operation ends. Any number of ticks that arrive during one operation produce a single extra reload.
- R8: A `usr_wr_req` pulse with `usr_wr_sel` (0 selects address 0x28, 1 selects 0x29) and `usr_wr_data` issues exactly one memory write, with `mem_we`=1, to that address with that data.
- R9: A write request that arrives during a reload is held until all five reads are done. It then runs as a separate busy period, after `busy` has been low for one cycle.
- R10: `busy` is high whenever `mem_req` is high. It falls only on the clock edge that ends an operation, which is the edge at which the last `mem_ack` is sampled.
- R11: When a reload and a write are both waiting, the reload runs first.
- R12: The shadow bytes change only when a read acknowledge arrives. User writes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hour_tick | input | 1 | One-cycle hourly pulse from timekeeping |
| usr_wr_req | input | 1 | One-cycle user write request |
| usr_wr_sel | input | 1 | Selects the application byte: 0 for 0x28, 1 for 0x29 |
| usr_wr_data | input | DW | Data for the user write |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data is valid in the same cycle |
| mem_rdata | input | DW | Memory read data |
| shadow_q | output | NF*DW | Shadow bytes, field i at bits [DW*i +: DW] |
| refresh_en | output | 1 | Periodic refresh enable, taken from the shadow control byte |
| busy | output | 1 | High while a load, reload or write is in progress |

## Verification
The bench varies the acknowledge latency from one to four cycles. Every reload must read exactly five bytes in order. A design that advanced on the request instead of on the acknowledge would fill the shadow bytes with stale data and misorder the addresses.

Several ticks are sent during one reload. A design without a queue would lose the extra reload, and one that counted ticks would run too many.

Writes are sent while a reload is running, and a write and a tick are queued together. Wrong arbitration would show up as a write placed in the middle of a read sequence, or as a write served ahead of the waiting reload.

Finally the refresh bit is cleared through a reload and the memory contents are then changed. Any tick that still starts a reload would then be caught by a changed shadow byte or by an extra read.

// File: rtl/cfgsh_pkg.sv
// Shared types for the configuration shadow refresh controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cfgsh_pkg;

    // Sequencer states: power-up entry, idle, config read burst, user write.
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } cfgsh_state_e;

endpackage

// File: rtl/cfgsh_req_latch.sv
// Pending-request latch: remembers qualified hourly ticks and user write
// requests that arrive while the sequencer is busy, and arbitrates
// (reload before write) when the sequencer is idle.
// Assumes: tick and write request are one-cycle pulses; the newest write
// request overwrites an older pending one.
module cfgsh_req_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          refresh_en,
    input  logic          idle,
    input  logic          wr_req_i,
    input  logic          wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          start_ref,
    output logic          start_wr,
    output logic          wr_sel_o,
    output logic [DW-1:0] wr_data_o
);

    logic          tick_pend;
    logic          wr_pend;
    logic          pend_sel;
    logic [DW-1:0] pend_data;
    logic          tick_hit;
    logic          ref_due;
    logic          wr_due;

    // Arbitration: a reload due wins over a write due.
    always_comb begin
        tick_hit  = tick_i && refresh_en;
        ref_due   = tick_pend || tick_hit;
        wr_due    = wr_pend || wr_req_i;
        start_ref = idle && ref_due;
        start_wr  = idle && !ref_due && wr_due;
        wr_sel_o  = wr_req_i ? wr_sel_i  : pend_sel;
        wr_data_o = wr_req_i ? wr_data_i : pend_data;
    end

    // Tick memory: absorbed when a reload starts, set by a qualified tick otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         tick_pend <= 1'b0;
        else if (start_ref) tick_pend <= 1'b0;
        else if (tick_hit)  tick_pend <= 1'b1;
    end

    // Write memory: holds request and payload until the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend   <= 1'b0;
            pend_sel  <= 1'b0;
            pend_data <= '0;
        end else if (wr_req_i && !start_wr) begin
            wr_pend   <= 1'b1;
            pend_sel  <= wr_sel_i;
            pend_data <= wr_data_i;
        end else if (start_wr) begin
            wr_pend   <= 1'b0;
        end
    end

endmodule

// File: rtl/cfgsh_seq.sv
// Operation sequencer: runs the power-up load, periodic reloads (NF reads
// in ascending address order) and single user writes over a held
// request / one-cycle acknowledge memory port.
// Assumes: mem_ack is high for one cycle per request; read data is valid
// in the acknowledge cycle.
module cfgsh_seq
    import cfgsh_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NF       = 5,
    parameter int CFG_BASE = 'h30,
    parameter int USR_BASE = 'h28,
    localparam int IW      = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ref,
    input  logic          start_wr,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          mem_ack,
    output logic          idle,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          load_en,
    output logic [IW-1:0] load_idx
);

    localparam logic [AW-1:0] CFG_A  = AW'(CFG_BASE);
    localparam logic [AW-1:0] USR_A  = AW'(USR_BASE);
    localparam logic [IW-1:0] LAST_I = IW'(NF - 1);

    cfgsh_state_e  state;
    logic [IW-1:0] idx;
    logic          act_sel;
    logic [DW-1:0] act_data;

    // State, field index and active write payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_BOOT;
            idx      <= '0;
            act_sel  <= 1'b0;
            act_data <= '0;
        end else begin
            case (state)
                ST_BOOT: begin
                    state <= ST_READ;
                    idx   <= '0;
                end
                ST_IDLE: begin
                    if (start_ref) begin
                        state <= ST_READ;
                        idx   <= '0;
                    end else if (start_wr) begin
                        state    <= ST_WRITE;
                        act_sel  <= wr_sel;
                        act_data <= wr_data;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (idx == LAST_I) state <= ST_IDLE;
                        else               idx   <= idx + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port and status decode from the current state.
    always_comb begin
        idle      = (state == ST_IDLE);
        busy      = !idle;
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? (USR_A + {{(AW-1){1'b0}}, act_sel})
                                        : (CFG_A + AW'(idx));
        mem_wdata = act_data;
        load_en   = (state == ST_READ) && mem_ack;
        load_idx  = idx;
    end

endmodule

// File: rtl/cfgsh_shadow_bank.sv
// Shadow register bank: NF volatile bytes, each loaded from read data
// when its index is acknowledged; exposes the refresh-enable control bit.
// Assumes: field 0 is the control byte holding the enable at REFEN_BIT.
module cfgsh_shadow_bank #(
    parameter int DW        = 8,
    parameter int NF        = 5,
    parameter int REFEN_BIT = 7,
    localparam int IW       = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IW-1:0]    load_idx,
    input  logic [DW-1:0]    load_data,
    output logic [NF*DW-1:0] shadow_q,
    output logic             refresh_en
);

    for (genvar i = 0; i < NF; i++) begin : g_field
        // One shadow byte, cleared by reset and written on its own acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[i*DW +: DW] <= '0;
            else if (load_en && (load_idx == IW'(i)))
                shadow_q[i*DW +: DW] <= load_data;
        end
    end

    // Refresh enable taken from the control field.
    assign refresh_en = shadow_q[REFEN_BIT];

endmodule

// File: rtl/cfg_shadow_refresh.sv
// Configuration shadow refresh controller top: loads NF configuration
// bytes after reset, reloads them on qualified hourly ticks, and performs
// user writes to the two application bytes; one busy flag covers all.
// Assumes: synchronous active-low reset; memory port per cfgsh_seq.
module cfg_shadow_refresh #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int NF        = 5,
    parameter int CFG_BASE  = 'h30,
    parameter int USR_BASE  = 'h28,
    parameter int REFEN_BIT = 7,
    localparam int IW       = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hour_tick,
    input  logic             usr_wr_req,
    input  logic             usr_wr_sel,
    input  logic [DW-1:0]    usr_wr_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic [NF*DW-1:0] shadow_q,
    output logic             refresh_en,
    output logic             busy
);

    logic          idle;
    logic          start_ref;
    logic          start_wr;
    logic          wr_sel;
    logic [DW-1:0] wr_data;
    logic          load_en;
    logic [IW-1:0] load_idx;

    cfgsh_req_latch #(.DW(DW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (hour_tick),
        .refresh_en (refresh_en),
        .idle       (idle),
        .wr_req_i   (usr_wr_req),
        .wr_sel_i   (usr_wr_sel),
        .wr_data_i  (usr_wr_data),
        .start_ref  (start_ref),
        .start_wr   (start_wr),
        .wr_sel_o   (wr_sel),
        .wr_data_o  (wr_data)
    );

    cfgsh_seq #(
        .AW(AW), .DW(DW), .NF(NF), .CFG_BASE(CFG_BASE), .USR_BASE(USR_BASE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ref (start_ref),
        .start_wr  (start_wr),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .mem_ack   (mem_ack),
        .idle      (idle),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .load_en   (load_en),
        .load_idx  (load_idx)
    );

    cfgsh_shadow_bank #(.DW(DW), .NF(NF), .REFEN_BIT(REFEN_BIT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .load_data  (mem_rdata),
        .shadow_q   (shadow_q),
        .refresh_en (refresh_en)
    );

endmodule

// File: rtl/cfgsh_checker.sv
// Protocol and status checker bound to cfg_shadow_refresh.
// Assumes: synchronous active-low reset; checks ports only.
module cfgsh_checker #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NF       = 5,
    parameter int CFG_BASE = 'h30,
    parameter int USR_BASE = 'h28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_ack,
    input logic [NF*DW-1:0] shadow_q,
    input logic             busy
);

    // R3: an unacknowledged request is held with address and direction stable.
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: no memory traffic outside a busy period.
    assert_busy_covers_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R10: busy only ends right after an acknowledge.
    assert_busy_fall_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_ack));

    // R12: shadow bytes hold unless a read acknowledge arrives.
    assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_ack && !mem_we) |=> $stable(shadow_q));

    // R8: writes go only to the two application bytes.
    assert_write_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            ((mem_addr == AW'(USR_BASE)) || (mem_addr == AW'(USR_BASE + 1))));

    // R2: reads stay inside the configuration window.
    assert_read_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |->
            ((mem_addr >= AW'(CFG_BASE)) && (mem_addr < AW'(CFG_BASE + NF))));

endmodule

bind cfg_shadow_refresh cfgsh_checker #(
    .AW(AW), .DW(DW), .NF(NF), .CFG_BASE(CFG_BASE), .USR_BASE(USR_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .shadow_q (shadow_q),
    .busy     (busy)
);

// File: tb/sim_cfg_shadow_refresh.sv
// Self-checking bench with a variable-latency memory model.
module sim_cfg_shadow_refresh;

    localparam int AW = 8, DW = 8, NF = 5;
    localparam int CFG_BASE = 'h30, USR_BASE = 'h28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hour_tick = 1'b0;
    logic usr_wr_req = 1'b0;
    logic usr_wr_sel = 1'b0;
    logic [DW-1:0] usr_wr_data = '0;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [NF*DW-1:0] shadow_q;
    logic refresh_en, busy;

    always #5 clk = ~clk;

    cfg_shadow_refresh u0 (
        .clk(clk), .rst_n(rst_n), .hour_tick(hour_tick),
        .usr_wr_req(usr_wr_req), .usr_wr_sel(usr_wr_sel), .usr_wr_data(usr_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .shadow_q(shadow_q), .refresh_en(refresh_en), .busy(busy)
    );

    // Memory model with backdoor port and programmable latency.
    logic [7:0] mem [0:255];
    int lat = 2;
    int cnt = 0;
    logic bd_we = 1'b0;
    logic [7:0] bd_addr = '0, bd_data = '0;
    initial mem_ack = 1'b0;
    initial mem_rdata = '0;

    always @(posedge clk) begin
        if (bd_we) mem[bd_addr] <= bd_data;
        if (!rst_n || mem_ack) begin
            mem_ack <= 1'b0;
            cnt <= 0;
        end else if (mem_req) begin
            if (cnt >= lat - 1) begin
                mem_ack <= 1'b1;
                cnt <= 0;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr];
            end else cnt <= cnt + 1;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: transaction log and handshake checks.
    int rd_count = 0, wr_count = 0, busy_rises = 0;
    int wl_addr [0:15];
    int wl_data [0:15];
    int wl_rd [0:15];
    logic p_req = 0, p_ack = 0, p_busy = 1;
    logic [7:0] p_addr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ack) begin
                if (!mem_we) begin
                    chk(mem_addr == 8'(CFG_BASE + rd_count % NF), "R2 read order",
                        mem_addr, CFG_BASE + rd_count % NF);
                    rd_count++;
                end else if (wr_count < 16) begin
                    wl_addr[wr_count] = mem_addr;
                    wl_data[wr_count] = mem_wdata;
                    wl_rd[wr_count]   = rd_count;
                    wr_count++;
                end
            end
            if (p_req && !p_ack)
                chk(mem_req && mem_addr == p_addr, "R3 request held", mem_addr, p_addr);
            if (p_busy && !busy)
                chk(p_ack == 1'b1, "R10 busy fall after ack", p_ack, 1);
            if (busy && !p_busy) busy_rises++;
        end
        p_req = mem_req; p_ack = mem_ack; p_busy = busy; p_addr = mem_addr;
    end

    task automatic bd_write(input int a, input int d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = 8'(a); bd_data = 8'(d);
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic load_cfg(input int seed, input bit en);
        for (int i = 0; i < NF; i++) begin
            int v = (seed * 37 + i * 13 + 5) & 8'hff;
            if (i == 0) v = en ? (v | 8'h80) : (v & 8'h7f);
            bd_write(CFG_BASE + i, v);
        end
    endtask

    task automatic wait_quiet;
        int quiet = 0;
        int n = 0;
        while (quiet < 4 && n < 2000) begin
            @(negedge clk);
            n++;
            quiet = busy ? 0 : quiet + 1;
        end
        chk(n < 2000, "R10 operation ends", n, 0);
    endtask

    task automatic pulse_tick;
        @(negedge clk); hour_tick = 1'b1;
        @(negedge clk); hour_tick = 1'b0;
    endtask

    task automatic pulse_wr(input bit sel, input int d);
        @(negedge clk); usr_wr_req = 1'b1; usr_wr_sel = sel; usr_wr_data = 8'(d);
        @(negedge clk); usr_wr_req = 1'b0;
    endtask

    task automatic chk_shadow_mem(input string req);
        for (int i = 0; i < NF; i++)
            chk(shadow_q[i*8 +: 8] == mem[CFG_BASE + i], req,
                shadow_q[i*8 +: 8], mem[CFG_BASE + i]);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NF*DW-1:0] snap;
        int base, wbase, rbase;

        // R1: reset state, then power-up load start.
        load_cfg(1, 1);
        bd_write(USR_BASE, 0); bd_write(USR_BASE + 1, 0);
        @(negedge clk);
        chk(shadow_q == '0, "R1 shadow reset", shadow_q[7:0], 0);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(mem_req == 1'b0, "R1 no request in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b1 && mem_addr == 8'(CFG_BASE), "R1 load starts", mem_addr, CFG_BASE);
        wait_quiet();
        chk(rd_count == NF, "R2 power-up read count", rd_count, NF);
        chk_shadow_mem("R2 power-up contents");
        chk(refresh_en == mem[CFG_BASE][7], "R4 enable from control", refresh_en, 1);

        // R5: hourly reload across acknowledge latencies.
        for (int l = 1; l <= 4; l++) begin
            lat = l;
            load_cfg(10 + l, 1);
            base = rd_count;
            pulse_tick();
            chk(busy == 1'b1, "R5 busy on tick", busy, 1);
            wait_quiet();
            chk(rd_count == base + NF, "R5 reload reads", rd_count - base, NF);
            chk_shadow_mem("R5 reload contents");
        end

        // R8/R12: user writes over latencies and both selects.
        for (int l = 1; l <= 3; l++) begin
            for (int s = 0; s < 2; s++) begin
                int d = l * 16 + s + 1;
                lat = l;
                snap = shadow_q; wbase = wr_count; rbase = rd_count;
                pulse_wr(s[0], d);
                chk(busy == 1'b1, "R8 busy on write", busy, 1);
                wait_quiet();
                chk(wr_count == wbase + 1, "R8 one write", wr_count - wbase, 1);
                chk(wl_addr[wbase] == USR_BASE + s, "R8 write address", wl_addr[wbase], USR_BASE + s);
                chk(wl_data[wbase] == d, "R8 write data", wl_data[wbase], d);
                chk(mem[USR_BASE + s] == 8'(d), "R8 memory updated", mem[USR_BASE + s], d);
                chk(shadow_q == snap && rd_count == rbase, "R12 shadow untouched by write",
                    shadow_q[7:0], snap[7:0]);
            end
        end

        // R7: several ticks during one reload collapse into one extra reload.
        lat = 3;
        base = rd_count; rbase = busy_rises;
        pulse_tick();
        repeat (3) @(negedge clk);
        pulse_tick();
        pulse_tick();
        wait_quiet();
        chk(rd_count == base + 2 * NF, "R7 one extra reload", rd_count - base, 2 * NF);
        chk(busy_rises == rbase + 2, "R7 busy periods", busy_rises - rbase, 2);

        // R9: write arriving during a reload waits for its end.
        lat = 2;
        base = rd_count; wbase = wr_count; rbase = busy_rises;
        pulse_tick();
        chk(busy == 1'b1, "R9 reload running", busy, 1);
        pulse_wr(1'b1, 8'hA5);
        wait_quiet();
        chk(wr_count == wbase + 1 && wl_rd[wbase] == base + NF, "R9 write after reads",
            wl_rd[wbase] - base, NF);
        chk(busy_rises == rbase + 2, "R9 separate busy period", busy_rises - rbase, 2);

        // R11: reload waiting beats a write waiting.
        lat = 4;
        base = rd_count; wbase = wr_count;
        pulse_wr(1'b0, 8'h3C);
        pulse_wr(1'b1, 8'hC3);
        pulse_tick();
        wait_quiet();
        chk(wr_count == wbase + 2, "R11 two writes", wr_count - wbase, 2);
        chk(wl_rd[wbase] == base, "R11 first write direct", wl_rd[wbase] - base, 0);
        chk(wl_rd[wbase + 1] == base + NF, "R11 reload before queued write",
            wl_rd[wbase + 1] - base, NF);
        chk(wl_data[wbase + 1] == 8'hC3, "R11 queued write data", wl_data[wbase + 1], 8'hC3);

        // R4/R6: clear the enable through a reload, then ticks are dropped.
        lat = 2;
        load_cfg(77, 0);
        pulse_tick();
        wait_quiet();
        chk(refresh_en == 1'b0, "R4 enable cleared", refresh_en, 0);
        chk_shadow_mem("R4 reload contents");
        load_cfg(78, 0);
        snap = shadow_q; base = rd_count;
        pulse_tick();
        chk(busy == 1'b0 && mem_req == 1'b0, "R6 tick ignored", busy, 0);
        repeat (10) @(negedge clk);
        chk(rd_count == base, "R6 no reads", rd_count - base, 0);
        chk(shadow_q == snap, "R6 shadow unchanged", shadow_q[15:8], snap[15:8]);

        // R1/R2: second power-up with new contents.
        rst_n = 1'b0;
        load_cfg(90, 1);
        chk(shadow_q == '0, "R1 shadow cleared again", shadow_q[7:0], 0);
        @(negedge clk); rst_n = 1'b1;
        wait_quiet();
        chk_shadow_mem("R2 second power-up contents");
        chk(refresh_en == 1'b1, "R4 enable restored", refresh_en, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule